// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer with auto-sleep

This block is the digital controller for an eight-input successive-approximation converter. The converter stays powered down until a trigger arrives. A trigger can come from a software strobe, an external pin, or an internal periodic timer. When one arrives, the block takes a copy of the channel-enable mask and powers the converter. It waits a programmable number of settling cycles. It then converts each enabled input in turn, starting with the lowest index, and skips the inputs that are disabled.

The converter is reached through a start/done handshake. The block issues a one-cycle start strobe together with an input select. It then waits for done and captures a 10-bit sample. Each sample goes into that channel's own result register and sets that channel's ready flag. When the last enabled channel has been stored, the converter is powered down again and a one-cycle completion pulse is issued.

A trigger that arrives while a pass is already running is dropped, and it sets a sticky overrun flag. A trigger that arrives with an all-zero mask leaves the converter asleep.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `adc_pwr_o`, `adc_start_o`, `ovr_o`, `seq_done_o` and all bits of `rdy_o` are 0.
- R2: A one-cycle pulse on `sw_trig_i` in sleep starts a pass. The pass issues exactly one start strobe per channel enabled in `ch_en_i`, in ascending channel index, and none for disabled channels.
- R3: The sample returned with `adc_done_i` for channel k is stored in `res_o[k*10 +: 10]`.
- R4: Storing channel k sets `rdy_o[k]`, which stays set until a cycle with `rdy_clr_i[k]` high.
- R5: The external pin is synchronised and edge-detected. `edge_sel_i` = 0 selects rising edges, 1 selects falling edges, and 2 selects both.
- R6: With `trig_sel_i` = 2, the internal timer triggers a pass every `tmr_period_i`+1 clock cycles.
- R7: `trig_sel_i` = 0 disables both hardware sources, 1 selects the external pin, and 2 selects the timer. An unselected source never starts a pass.
- R8: The first start strobe of a pass comes exactly `wake_dly_i` cycles after `adc_pwr_o` rises. A delay of 0 gives a start in the same cycle as power-up.
- R9: `adc_pwr_o` falls in the cycle after the last done of a pass, and `seq_done_o` is high for exactly that one cycle.
- R10: A trigger while `adc_pwr_o` is high starts nothing extra and sets `ovr_o`. `ovr_o` stays set until a cycle with `ovr_clr_i` high.
- R11: A trigger that arrives with `ch_en_i` = 0 leaves `adc_pwr_o` low and issues no start strobe.
- R12: The channel set of a pass is the mask present when the pass was triggered. Changes to `ch_en_i` during the pass are ignored.
- R13: `adc_start_o` is asserted only while `adc_pwr_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | 8 | Channel enable mask |
| trig_sel_i | input | 2 | Hardware trigger source: 0 none, 1 pin, 2 timer |
| edge_sel_i | input | 2 | Pin edge: 0 rising, 1 falling, 2 both |
| sw_trig_i | input | 1 | Software trigger strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| tmr_period_i | input | 16 | Timer period minus one, in cycles |
| wake_dly_i | input | 8 | Settling cycles after power-up |
| adc_pwr_o | output | 1 | Converter power enable |
| adc_start_o | output | 1 | Conversion start strobe |
| adc_ch_o | output | 3 | Input mux select |
| adc_done_i | input | 1 | Conversion done strobe |
| adc_data_i | input | 10 | Conversion sample |
| res_o | output | 80 | Per-channel results, channel k at bits k*10+9..k*10 |
| rdy_o | output | 8 | Per-channel ready flags |
| rdy_clr_i | input | 8 | Per-channel ready clear |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Overrun clear |
| seq_done_o | output | 1 | End-of-pass pulse |

## Verification
The bench uses sparse masks with gaps, so that a sequencer which walks every channel, or walks them in the wrong order, leaves extra or misordered strobes in the converter model's log. It measures the power-to-start distance for both a nonzero wake delay and a zero wake delay; an off-by-one counter shows up as a one-cycle error. Overrun, a mask change mid-pass, and an empty-mask trigger are each checked by counting start strobes and power-ups, so a design that queues the late trigger, follows the live mask, or wakes with nothing to do produces the wrong counts. Each pin edge mode is driven with both edge directions, and the timer is checked against the exact spacing between two power-ups.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_START = 2'd2,
    ST_WAIT  = 2'd3
  } seq_st_e;

  localparam logic [1:0] TRG_NONE = 2'd0;
  localparam logic [1:0] TRG_EXT  = 2'd1;
  localparam logic [1:0] TRG_TMR  = 2'd2;

  localparam logic [1:0] EDG_RISE = 2'd0;
  localparam logic [1:0] EDG_FALL = 2'd1;
  localparam logic [1:0] EDG_BOTH = 2'd2;
endpackage

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
  import adc_seq_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [1:0]       edge_i,
  input  logic             sw_i,
  input  logic             ext_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             trig_o
);
  // synchroniser chain plus one history stage
  logic [SYNC_N:0] sync_q;
  logic            rise, fall, ext_hit, ext_evt_q;
  logic [TMR_W-1:0] tmr_q;
  logic            tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-1:0], ext_i};
  end

  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];

  always_comb begin
    unique case (edge_i)
      EDG_FALL: ext_hit = fall;
      EDG_BOTH: ext_hit = rise | fall;
      default:  ext_hit = rise;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_evt_q <= 1'b0;
    else         ext_evt_q <= ext_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      tick_q <= 1'b0;
    end else if (sel_i != TRG_TMR) begin
      tmr_q  <= '0;
      tick_q <= 1'b0;
    end else if (tmr_q >= period_i) begin
      tmr_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      tmr_q  <= tmr_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign trig_o = sw_i
                | ((sel_i == TRG_EXT) & ext_evt_q)
                | ((sel_i == TRG_TMR) & tick_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int WAKE_W = 8,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [N_CH-1:0]   mask_i,
  input  logic [WAKE_W-1:0] wake_dly_i,
  input  logic              done_i,
  output logic              pwr_o,
  output logic              start_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              wr_o,
  output logic              seq_done_o,
  output logic              ovr_set_o
);
  seq_st_e           st_q, st_d;
  logic [N_CH-1:0]   pend_q, pend_d, pend_clr;
  logic [WAKE_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]   cur;
  logic              fin_q, fin_d;

  function automatic logic [CH_W-1:0] lowest(input logic [N_CH-1:0] m);
    lowest = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (m[i]) lowest = CH_W'(i);
  endfunction

  assign cur = lowest(pend_q);

  always_comb begin
    pend_clr      = pend_q;
    pend_clr[cur] = 1'b0;
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    fin_d  = 1'b0;
    unique case (st_q)
      ST_SLEEP: if (trig_i && (mask_i != '0)) begin
        pend_d = mask_i;
        cnt_d  = wake_dly_i;
        st_d   = (wake_dly_i == '0) ? ST_START : ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt_q <= 1) st_d = ST_START;
        else            cnt_d = cnt_q - 1'b1;
      end
      ST_START: st_d = ST_WAIT;
      ST_WAIT: if (done_i) begin
        pend_d = pend_clr;
        if (pend_clr == '0) begin
          st_d  = ST_SLEEP;
          fin_d = 1'b1;
        end else begin
          st_d = ST_START;
        end
      end
      default: st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SLEEP;
      pend_q <= '0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      fin_q  <= fin_d;
    end
  end

  assign pwr_o      = (st_q != ST_SLEEP);
  assign start_o    = (st_q == ST_START);
  assign ch_o       = cur;
  assign wr_o       = (st_q == ST_WAIT) && done_i;
  assign seq_done_o = fin_q;
  assign ovr_set_o  = trig_i && (st_q != ST_SLEEP);
endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter int N_CH  = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [CH_W-1:0]       ch_i,
  input  logic [RES_W-1:0]      data_i,
  input  logic [N_CH-1:0]       clr_i,
  output logic [N_CH*RES_W-1:0] res_o,
  output logic [N_CH-1:0]       rdy_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [RES_W-1:0] res_q;
    logic             rdy_q;
    logic             hit;

    assign hit = wr_i && (ch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= '0;
        rdy_q <= 1'b0;
      end else begin
        if (hit) res_q <= data_i;
        // a store wins over a clear in the same cycle
        if (hit)           rdy_q <= 1'b1;
        else if (clr_i[g]) rdy_q <= 1'b0;
      end
    end

    assign res_o[g*RES_W +: RES_W] = res_q;
    assign rdy_o[g]                = rdy_q;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int RES_W  = 10,
  parameter int TMR_W  = 16,
  parameter int WAKE_W = 8,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       ch_en_i,
  input  logic [1:0]            trig_sel_i,
  input  logic [1:0]            edge_sel_i,
  input  logic                  sw_trig_i,
  input  logic                  ext_trig_i,
  input  logic [TMR_W-1:0]      tmr_period_i,
  input  logic [WAKE_W-1:0]     wake_dly_i,
  output logic                  adc_pwr_o,
  output logic                  adc_start_o,
  output logic [CH_W-1:0]       adc_ch_o,
  input  logic                  adc_done_i,
  input  logic [RES_W-1:0]      adc_data_i,
  output logic [N_CH*RES_W-1:0] res_o,
  output logic [N_CH-1:0]       rdy_o,
  input  logic [N_CH-1:0]       rdy_clr_i,
  output logic                  ovr_o,
  input  logic                  ovr_clr_i,
  output logic                  seq_done_o
);
  logic trig, wr, ovr_set, ovr_q;

  adc_trig_unit #(.TMR_W(TMR_W)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (trig_sel_i),
    .edge_i   (edge_sel_i),
    .sw_i     (sw_trig_i),
    .ext_i    (ext_trig_i),
    .period_i (tmr_period_i),
    .trig_o   (trig)
  );

  adc_seq_ctrl #(.N_CH(N_CH), .WAKE_W(WAKE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .mask_i     (ch_en_i),
    .wake_dly_i (wake_dly_i),
    .done_i     (adc_done_i),
    .pwr_o      (adc_pwr_o),
    .start_o    (adc_start_o),
    .ch_o       (adc_ch_o),
    .wr_o       (wr),
    .seq_done_o (seq_done_o),
    .ovr_set_o  (ovr_set)
  );

  adc_res_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .ch_i   (adc_ch_o),
    .data_i (adc_data_i),
    .clr_i  (rdy_clr_i),
    .res_o  (res_o),
    .rdy_o  (rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_set)   ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int N_CH  = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sw_trig_i,
  input logic [N_CH-1:0] ch_en_i,
  input logic            adc_pwr_o,
  input logic            adc_start_o,
  input logic [CH_W-1:0] adc_ch_o,
  input logic            adc_done_i,
  input logic [N_CH-1:0] rdy_o,
  input logic            ovr_o,
  input logic            seq_done_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          outst_q <= 1'b0;
    else if (adc_start_o) outst_q <= 1'b1;
    else if (adc_done_i)  outst_q <= 1'b0;
  end

  // R13
  start_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> adc_pwr_o);

  // R11
  empty_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_pwr_o && ch_en_i == '0) |=> !adc_pwr_o);

  // R9
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_pwr_o) |-> seq_done_o);

  // R9
  done_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !adc_pwr_o);

  // R4
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_done_i && outst_q) |=> rdy_o[$past(adc_ch_o)]);

  // R10
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_trig_i && adc_pwr_o) |=> ovr_o);
endmodule

bind adc_seq_top adc_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_trig_i   (sw_trig_i),
  .ch_en_i     (ch_en_i),
  .adc_pwr_o   (adc_pwr_o),
  .adc_start_o (adc_start_o),
  .adc_ch_o    (adc_ch_o),
  .adc_done_i  (adc_done_i),
  .rdy_o       (rdy_o),
  .ovr_o       (ovr_o),
  .seq_done_o  (seq_done_o)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ch_en = '0;
  logic [1:0]  trig_sel = 2'd0;
  logic [1:0]  edge_sel = 2'd0;
  logic        sw_trig = 1'b0;
  logic        ext_trig = 1'b0;
  logic [15:0] tmr_period = 16'd0;
  logic [7:0]  wake_dly = 8'd0;
  logic        adc_pwr, adc_start, adc_done = 1'b0;
  logic [2:0]  adc_ch;
  logic [9:0]  adc_data = '0;
  logic [79:0] res;
  logic [7:0]  rdy;
  logic [7:0]  rdy_clr = '0;
  logic        ovr;
  logic        ovr_clr = 1'b0;
  logic        seq_done;

  always #4 clk = ~clk;

  adc_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(ch_en), .trig_sel_i(trig_sel),
    .edge_sel_i(edge_sel), .sw_trig_i(sw_trig), .ext_trig_i(ext_trig),
    .tmr_period_i(tmr_period), .wake_dly_i(wake_dly), .adc_pwr_o(adc_pwr),
    .adc_start_o(adc_start), .adc_ch_o(adc_ch), .adc_done_i(adc_done),
    .adc_data_i(adc_data), .res_o(res), .rdy_o(rdy), .rdy_clr_i(rdy_clr),
    .ovr_o(ovr), .ovr_clr_i(ovr_clr), .seq_done_o(seq_done)
  );

  int total = 0, bad = 0;
  int log_ch [0:31];
  int log_n = 0, n_wake = 0, wk = 0, first_wake = 0, cyc = 0;
  int rise_prev = 0, rise_last = 0, cv = 0, hold_ch = 0, seq_tag = 0, n_done = 0;
  logic started = 1'b0, pwr_prev = 1'b0, done_seen = 1'b0;

  function automatic logic [9:0] samp(input int ch, input int tag);
    return 10'((ch * 73 + tag * 11 + 5) & 10'h3ff);
  endfunction

  // converter model and observers, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (seq_done) n_done++;
    if (adc_pwr && !pwr_prev) begin
      n_wake++; wk = 0; started = 1'b0;
      rise_prev = rise_last; rise_last = cyc;
    end
    if (adc_pwr && !started && !adc_start) wk++;
    if (adc_start) begin
      if (!started) begin first_wake = wk; started = 1'b1; end
      if (log_n < 32) log_ch[log_n] = adc_ch;
      log_n++;
      hold_ch = adc_ch; cv = 3; adc_done = 1'b0;
    end else if (cv > 0) begin
      cv--;
      if (cv == 0) begin adc_done = 1'b1; adc_data = samp(hold_ch, seq_tag); end
      else adc_done = 1'b0;
    end else adc_done = 1'b0;
    if (!adc_pwr && pwr_prev) done_seen = seq_done;
    pwr_prev = adc_pwr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
  endtask

  task automatic wait_sleep();
    for (int i = 0; i < 400 && adc_pwr; i++) @(negedge clk);
    cyc_n(2);
  endtask

  task automatic clear_log();
    log_n = 0;
  endtask

  task automatic chk_pass(input logic [7:0] m, input string req);
    int k = 0;
    for (int c = 0; c < 8; c++) if (m[c]) begin
      chk(k < log_n && log_ch[k] == c, req, (k < log_n) ? log_ch[k] : -1, c);
      chk(res[c*10 +: 10] == samp(c, seq_tag), "R3", int'(res[c*10 +: 10]), int'(samp(c, seq_tag)));
      k++;
    end
    chk(log_n == k, req, log_n, k);
  endtask

  task automatic t_reset();
    chk(!adc_pwr && !adc_start, "R1", int'(adc_pwr), 0);
    chk(rdy == 8'h00 && !ovr && !seq_done, "R1", int'(rdy), 0);
  endtask

  task automatic t_sw_seq();
    int nd;
    seq_tag = 1; ch_en = 8'b1010_0110; wake_dly = 8'd5; clear_log();
    nd = n_done;
    pulse_sw();
    wait_sleep();
    chk_pass(8'b1010_0110, "R2");
    chk(rdy == 8'b1010_0110, "R4", int'(rdy), 8'b1010_0110);
    chk(first_wake == 5, "R8", first_wake, 5);
    chk(done_seen && n_done == nd + 1, "R9", n_done - nd, 1);
    chk(!ovr, "R10", int'(ovr), 0);
  endtask

  task automatic t_rdy_clr();
    @(negedge clk) rdy_clr = 8'b0000_0110;
    @(negedge clk) rdy_clr = '0;
    chk(rdy == 8'b1010_0000, "R4", int'(rdy), 8'b1010_0000);
  endtask

  task automatic t_wake_zero();
    seq_tag = 2; ch_en = 8'b1000_0001; wake_dly = 8'd0; clear_log();
    pulse_sw();
    wait_sleep();
    chk(first_wake == 0, "R8", first_wake, 0);
    chk_pass(8'b1000_0001, "R2");
  endtask

  task automatic t_empty();
    int nw;
    ch_en = '0; clear_log(); nw = n_wake;
    pulse_sw();
    cyc_n(20);
    chk(n_wake == nw && log_n == 0, "R11", n_wake - nw, 0);
  endtask

  task automatic t_overrun();
    seq_tag = 3; ch_en = 8'b0001_1000; wake_dly = 8'd2; clear_log();
    pulse_sw();
    cyc_n(4);
    pulse_sw();
    wait_sleep();
    chk(ovr, "R10", int'(ovr), 1);
    chk(log_n == 2, "R10", log_n, 2);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk(!ovr, "R10", int'(ovr), 0);
  endtask

  task automatic t_snapshot();
    seq_tag = 4; ch_en = 8'b0000_0011; wake_dly = 8'd3; clear_log();
    pulse_sw();
    cyc_n(2);
    ch_en = 8'hff;
    wait_sleep();
    chk_pass(8'b0000_0011, "R12");
  endtask

  task automatic ext_to(input logic v, input int exp_wakes, input string req);
    int nw;
    nw = n_wake;
    @(negedge clk) ext_trig = v;
    cyc_n(40);
    wait_sleep();
    chk(n_wake - nw == exp_wakes, req, n_wake - nw, exp_wakes);
  endtask

  task automatic t_ext();
    seq_tag = 5; ch_en = 8'b0100_0000; wake_dly = 8'd1;
    trig_sel = 2'd0;
    ext_to(1'b1, 0, "R7");
    ext_to(1'b0, 0, "R7");
    trig_sel = 2'd1; edge_sel = 2'd0;
    ext_to(1'b1, 1, "R5");
    ext_to(1'b0, 0, "R5");
    edge_sel = 2'd1;
    ext_to(1'b1, 0, "R5");
    ext_to(1'b0, 1, "R5");
    edge_sel = 2'd2;
    ext_to(1'b1, 1, "R5");
    ext_to(1'b0, 1, "R5");
    trig_sel = 2'd2; tmr_period = 16'd40000;
    ext_to(1'b1, 0, "R7");
    trig_sel = 2'd0;
    ext_to(1'b0, 0, "R7");
  endtask

  task automatic t_timer();
    int nw;
    seq_tag = 6; ch_en = 8'b0000_0100; wake_dly = 8'd2; tmr_period = 16'd40;
    nw = n_wake;
    @(negedge clk) trig_sel = 2'd2;
    cyc_n(100);
    @(negedge clk) trig_sel = 2'd0;
    wait_sleep();
    chk(n_wake - nw >= 2, "R6", n_wake - nw, 2);
    chk(rise_last - rise_prev == 41, "R6", rise_last - rise_prev, 41);
    chk(!ovr, "R6", int'(ovr), 0);
  endtask

  initial begin
    fork
      begin
        cyc_n(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        cyc_n(2);
        t_reset();
        t_sw_seq();
        t_rdy_clr();
        t_wake_zero();
        t_empty();
        t_overrun();
        t_snapshot();
        t_ext();
        t_timer();
      end
      begin
        cyc_n(100000);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule